// File: doc/BRIEF.md
# Chained Serial DAC Frame Writer

This controller sits on the host side of a row of 16-bit serial digital-to-analog converters that are wired one after another through their serial outputs. All converters share one serial clock, one data line, one active-low input-register enable, one active-low output-latch enable and one active-low clear line. On a start pulse the controller takes a flat vector of `NUM_DEV` words and shifts it as a single frame of `16*NUM_DEV` bits. It then gives one extra serial clock cycle in which only the latch enable is low, so every converter's output changes on the same edge.

The serial clock is produced by dividing the system clock. Data and enable changes are made only where the serial clock falls, so the converters sample stable values on the rising edge. A clear request takes priority over everything else. It abandons any frame in flight and drives the shared clear line low for a fixed number of system cycles, which returns every converter to midscale. `busy_o` covers the whole frame or clear sequence, and `done_o` marks the end of a completed frame.

Top module: `dchain_ctrl`

## Requirements
- R1: After reset the serial clock is low, the input enable, latch enable and clear lines are high, and both `busy_o` and `done_o` are low.
- R2: Word k of `words_i` (bits `[16k+15:16k]`) is meant for device k, with device 0 next to the host. A frame has exactly `16*NUM_DEV` rising serial edges with the input enable low. The word for device `NUM_DEV-1` goes out first, and each word is sent most significant bit first.
- R3: While a frame runs, each high phase and each low phase of the serial clock lasts exactly `HALF_DIV` system cycles.
- R4: `sdata_o` never changes while the serial clock is high, so it is stable across every rising edge.
- R5: After the last data bit there is exactly one rising serial edge with the input enable high and the latch enable low. All devices take their new words on that one edge.
- R6: The input enable and the latch enable are never low at the same time.
- R7: `busy_o` is high from the cycle after an accepted start until the frame ends. `done_o` is high for exactly one system cycle at the end of each completed frame, with `busy_o` already low.
- R8: A start pulse while `busy_o` is high is ignored. The frame in flight completes with its original words, and no second frame follows.
- R9: A clear request aborts any frame. It drives `clr_n_o` low for exactly `CLR_CYC` system cycles with the serial clock low and both enables high. It produces no `done_o`, and then the controller returns to idle.
- R10: A clear request that arrives in the same cycle as a start pulse wins. No frame is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a frame (one-cycle pulse) |
| words_i | input | 16*NUM_DEV | Words, device k at bits [16k+15:16k] |
| clear_i | input | 1 | Request a clear of all converters |
| sclk_o | output | 1 | Divided serial clock |
| sdata_o | output | 1 | Serial data, first device in chain |
| ld_in_n_o | output | 1 | Active-low input shift register enable |
| upd_n_o | output | 1 | Active-low output latch enable |
| clr_n_o | output | 1 | Active-low clear to all converters |
| busy_o | output | 1 | Frame or clear sequence running |
| done_o | output | 1 | One-cycle pulse at frame end |

## Verification
The assertions assume that `clear_i` and `start_i` are synchronous to `clk`, and that `words_i` needs to be valid only in the cycle of an accepted start. The bench drives every input at the falling system edge. It makes start and clear single-cycle pulses, and it changes `words_i` only together with a start. A behavioural chain of three converters follows the serial pins and supplies the latch contents. Those contents are then compared against words queued by the driver.

// File: rtl/dchain_pkg.sv
package dchain_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_LOAD  = 2'd2,
        ST_CLEAR = 2'd3
    } dchain_st_e;
endpackage

// File: rtl/dchain_tick.sv
// Half-period tick generator for the serial clock.
module dchain_tick #(
    parameter int HALF_DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign tick_o = run_i && (cnt_q == CNT_W'(HALF_DIV - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i || tick_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/dchain_sreg.sv
// Frame shift register, most significant bit leaves first.
module dchain_sreg #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    input  logic         shift_i,
    output logic         msb_o
);
    logic [W-1:0] sr_d, sr_q;

    assign msb_o = sr_q[W-1];

    always_comb begin
        sr_d = sr_q;
        if (load_i) begin
            sr_d = val_i;
        end else if (shift_i) begin
            sr_d = {sr_q[W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else begin
            sr_q <= sr_d;
        end
    end
endmodule

// File: rtl/dchain_ctrl.sv
module dchain_ctrl
    import dchain_pkg::*;
#(
    parameter int NUM_DEV  = 3,
    parameter int WORD_W   = 16,
    parameter int HALF_DIV = 10,
    parameter int CLR_CYC  = 20
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic [NUM_DEV*WORD_W-1:0] words_i,
    input  logic                      clear_i,
    output logic                      sclk_o,
    output logic                      sdata_o,
    output logic                      ld_in_n_o,
    output logic                      upd_n_o,
    output logic                      clr_n_o,
    output logic                      busy_o,
    output logic                      done_o
);
    localparam int FRAME_W = NUM_DEV * WORD_W;
    localparam int BIT_W   = $clog2(FRAME_W);
    localparam int CLR_W   = $clog2(CLR_CYC + 1);

    typedef struct packed {
        dchain_st_e       st;
        logic             sclk;
        logic             ldn;
        logic             updn;
        logic             clrn;
        logic             done;
        logic [BIT_W-1:0] bitcnt;
        logic [CLR_W-1:0] clrcnt;
    } ctrl_t;

    ctrl_t q, d;
    logic  run, tick, sr_load, sr_shift, sr_msb;

    assign run = (q.st == ST_SHIFT) || (q.st == ST_LOAD);

    dchain_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .tick_o (tick)
    );

    dchain_sreg #(.W(FRAME_W)) u_sreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (sr_load),
        .val_i   (words_i),
        .shift_i (sr_shift),
        .msb_o   (sr_msb)
    );

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        sr_load  = 1'b0;
        sr_shift = 1'b0;
        if (clear_i) begin
            // clear wins over start and over any frame in flight
            d.st     = ST_CLEAR;
            d.sclk   = 1'b0;
            d.ldn    = 1'b1;
            d.updn   = 1'b1;
            d.clrn   = 1'b0;
            d.clrcnt = '0;
        end else begin
            unique case (q.st)
                ST_IDLE: begin
                    if (start_i) begin
                        d.st     = ST_SHIFT;
                        d.ldn    = 1'b0;
                        d.bitcnt = '0;
                        sr_load  = 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (!q.sclk) begin
                            d.sclk = 1'b1;
                        end else begin
                            d.sclk = 1'b0;
                            if (q.bitcnt == BIT_W'(FRAME_W - 1)) begin
                                d.st   = ST_LOAD;
                                d.ldn  = 1'b1;
                                d.updn = 1'b0;
                            end else begin
                                d.bitcnt = q.bitcnt + BIT_W'(1);
                                sr_shift = 1'b1;
                            end
                        end
                    end
                end
                ST_LOAD: begin
                    if (tick) begin
                        if (!q.sclk) begin
                            d.sclk = 1'b1;
                        end else begin
                            d.sclk = 1'b0;
                            d.updn = 1'b1;
                            d.done = 1'b1;
                            d.st   = ST_IDLE;
                        end
                    end
                end
                ST_CLEAR: begin
                    if (q.clrcnt == CLR_W'(CLR_CYC - 1)) begin
                        d.clrn = 1'b1;
                        d.st   = ST_IDLE;
                    end else begin
                        d.clrcnt = q.clrcnt + CLR_W'(1);
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st     <= ST_IDLE;
            q.sclk   <= 1'b0;
            q.ldn    <= 1'b1;
            q.updn   <= 1'b1;
            q.clrn   <= 1'b1;
            q.done   <= 1'b0;
            q.bitcnt <= '0;
            q.clrcnt <= '0;
        end else begin
            q <= d;
        end
    end

    assign sclk_o    = q.sclk;
    assign sdata_o   = (q.st == ST_SHIFT) && sr_msb;
    assign ld_in_n_o = q.ldn;
    assign upd_n_o   = q.updn;
    assign clr_n_o   = q.clrn;
    assign busy_o    = (q.st != ST_IDLE);
    assign done_o    = q.done;
endmodule

module dchain_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic clear_i,
    input logic sclk_o,
    input logic sdata_o,
    input logic ld_in_n_o,
    input logic upd_n_o,
    input logic clr_n_o,
    input logic busy_o,
    input logic done_o
);
    a_r6_enables_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ld_in_n_o && !upd_n_o));

    a_r4_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(sdata_o));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !clear_i) |=> busy_o);

    a_r9_clear_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n_o |-> (ld_in_n_o && upd_n_o && !sclk_o && busy_o && !done_o));

    a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && start_i) |=> (!clr_n_o && ld_in_n_o));

    a_r2_shift_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_in_n_o |-> busy_o);
endmodule

bind dchain_ctrl dchain_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .clear_i   (clear_i),
    .sclk_o    (sclk_o),
    .sdata_o   (sdata_o),
    .ld_in_n_o (ld_in_n_o),
    .upd_n_o   (upd_n_o),
    .clr_n_o   (clr_n_o),
    .busy_o    (busy_o),
    .done_o    (done_o)
);

// File: tb/dchain_ctrl_tb.sv
module dchain_ctrl_tb;
    localparam int CLK_NS   = 10;
    localparam int NUM_DEV  = 3;
    localparam int WORD_W   = 16;
    localparam int HALF_DIV = 10;
    localparam int CLR_CYC  = 20;
    localparam int FW       = NUM_DEV * WORD_W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          clear_i = 1'b0;
    logic [FW-1:0] words_i = '0;
    logic sclk_o, sdata_o, ld_in_n_o, upd_n_o, clr_n_o, busy_o, done_o;

    int total = 0;
    int bad   = 0;

    dchain_ctrl #(
        .NUM_DEV(NUM_DEV), .WORD_W(WORD_W), .HALF_DIV(HALF_DIV), .CLR_CYC(CLR_CYC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .words_i(words_i),
        .clear_i(clear_i), .sclk_o(sclk_o), .sdata_o(sdata_o),
        .ld_in_n_o(ld_in_n_o), .upd_n_o(upd_n_o), .clr_n_o(clr_n_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    always #(CLK_NS/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // behavioural converter chain: device 0 is fed by sdata_o
    logic [WORD_W-1:0] sr  [NUM_DEV] = '{default: '0};
    logic [WORD_W-1:0] lat [NUM_DEV] = '{default: '0};
    int sh_edges = 0;
    int ld_edges = 0;

    always @(posedge sclk_o or negedge clr_n_o) begin
        if (!clr_n_o) begin
            for (int k = 0; k < NUM_DEV; k++) begin
                sr[k]  <= '0;
                lat[k] <= '0;
            end
        end else if (!ld_in_n_o) begin
            sh_edges <= sh_edges + 1;
            sr[0] <= {sr[0][WORD_W-2:0], sdata_o};
            for (int k = 1; k < NUM_DEV; k++)
                sr[k] <= {sr[k][WORD_W-2:0], sr[k-1][WORD_W-1]};
        end else if (!upd_n_o) begin
            ld_edges <= ld_edges + 1;
            for (int k = 0; k < NUM_DEV; k++) lat[k] <= sr[k];
        end
    end

    // scoreboard
    logic [FW-1:0] expq [$];
    int done_seen = 0;
    int viol_r6 = 0, viol_r4 = 0, viol_r3 = 0;
    logic prev_sclk = 1'b0, prev_sdata = 1'b0, prev_clrn = 1'b1;
    int hi_run = 0, lo_run = 0, clr_run = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!ld_in_n_o && !upd_n_o) viol_r6++;
            if (sclk_o && sdata_o !== prev_sdata) viol_r4++;
            if (sclk_o) begin
                if (!prev_sclk && busy_o && lo_run != HALF_DIV) viol_r3++;
                hi_run++;
                lo_run = 0;
            end else begin
                if (prev_sclk && hi_run != HALF_DIV) viol_r3++;
                hi_run = 0;
                lo_run = busy_o ? lo_run + 1 : 0;
            end
            if (!clr_n_o) clr_run++;
            else if (!prev_clrn) begin
                chk(clr_run == CLR_CYC, "R9 clear width", clr_run, CLR_CYC);
                clr_run = 0;
            end
            if (done_o) begin
                done_seen++;
                chk(!busy_o, "R7 busy low at done", busy_o, 0);
                if (expq.size() == 0) begin
                    chk(0, "R7 unexpected done", 1, 0);
                end else begin
                    logic [FW-1:0] w;
                    w = expq.pop_front();
                    for (int k = 0; k < NUM_DEV; k++)
                        chk(lat[k] == w[k*WORD_W +: WORD_W], "R2 R5 device latch",
                            lat[k], w[k*WORD_W +: WORD_W]);
                end
            end
            prev_sclk  = sclk_o;
            prev_sdata = sdata_o;
            prev_clrn  = clr_n_o;
        end
    end

    task automatic send(input logic [FW-1:0] w);
        int s0, l0, d0;
        while (busy_o) @(negedge clk);
        s0 = sh_edges; l0 = ld_edges; d0 = done_seen;
        words_i = w;
        start_i = 1'b1;
        expq.push_back(w);
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o, "R7 busy after start", busy_o, 1);
        while (done_seen == d0) @(negedge clk);
        chk(sh_edges - s0 == FW, "R2 shift edges", sh_edges - s0, FW);
        chk(ld_edges - l0 == 1, "R5 latch edges", ld_edges - l0, 1);
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        clear_i = 1'b1;
        @(negedge clk);
        clear_i = 1'b0;
    endtask

    initial begin
        #(CLK_NS * 150000);
        chk(0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!sclk_o && ld_in_n_o && upd_n_o && clr_n_o, "R1 pins idle",
            {sclk_o, ld_in_n_o, upd_n_o, clr_n_o}, 4'b0111);
        chk(!busy_o && !done_o, "R1 status", {busy_o, done_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        send({16'h7FFF, 16'h8000, 16'h0001});
        send({16'hFFFF, 16'h0000, 16'hA5C3});
        send({16'h1234, 16'h5678, 16'h9ABC});

        // R8: start during a frame is ignored
        begin
            int d0;
            d0 = done_seen;
            words_i = {16'h0F0F, 16'hF0F0, 16'h3C3C};
            start_i = 1'b1;
            expq.push_back(words_i);
            @(negedge clk);
            start_i = 1'b0;
            repeat (200) @(negedge clk);
            words_i = {16'hDEAD, 16'hBEEF, 16'hCAFE};
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            chk(busy_o, "R8 still busy", busy_o, 1);
            while (done_seen == d0) @(negedge clk);
            repeat (1200) @(negedge clk);
            chk(done_seen == d0 + 1, "R8 single done", done_seen - d0, 1);
            chk(!busy_o, "R8 idle after", busy_o, 0);
        end

        // R9: clear aborts a frame, converters go to midscale code 0
        begin
            int d0;
            d0 = done_seen;
            words_i = {16'h1111, 16'h2222, 16'h3333};
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            repeat (300) @(negedge clk);
            pulse_clear();
            chk(!clr_n_o && busy_o && ld_in_n_o && upd_n_o, "R9 clear active",
                {clr_n_o, busy_o, ld_in_n_o, upd_n_o}, 4'b0111);
            repeat (CLR_CYC + 5) @(negedge clk);
            chk(!busy_o && clr_n_o, "R9 back to idle", {busy_o, clr_n_o}, 2'b01);
            for (int k = 0; k < NUM_DEV; k++)
                chk(lat[k] == '0, "R9 latch cleared", lat[k], 0);
            repeat (1200) @(negedge clk);
            chk(done_seen == d0, "R9 no done", done_seen - d0, 0);
        end

        // R10: clear and start together, clear wins
        begin
            int d0, s0;
            d0 = done_seen; s0 = sh_edges;
            words_i = {16'h4444, 16'h5555, 16'h6666};
            start_i = 1'b1;
            clear_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            clear_i = 1'b0;
            chk(!clr_n_o && ld_in_n_o, "R10 clear wins", {clr_n_o, ld_in_n_o}, 2'b01);
            repeat (1200) @(negedge clk);
            chk(done_seen == d0 && sh_edges == s0, "R10 no frame", sh_edges - s0, 0);
        end

        // clear while idle, then a fresh frame still works
        pulse_clear();
        repeat (CLR_CYC + 5) @(negedge clk);
        send({16'h8001, 16'h7FFE, 16'hC000});

        chk(viol_r6 == 0, "R6 enables exclusive", viol_r6, 0);
        chk(viol_r4 == 0, "R4 data stable", viol_r4, 0);
        chk(viol_r3 == 0, "R3 phase widths", viol_r3, 0);
        chk(expq.size() == 0, "R7 all frames done", expq.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule